// File: doc/BRIEF.md
# Windowed Three-Level Interrupt Aggregator

This block gathers a large set of interrupt input lines into a single level interrupt towards a processor. The lines are grouped eight to a block and eight blocks to a master. Each line has its own trigger setting: edge or level, and for each direction a mask bit. An event that matches the setting latches a pending bit. The pending bits are summarised per block, then per master, then in one root byte. Software walks this tree from the root downwards to find the lines that need service.

Software reaches the block through a byte-wide register port with a 10-bit address. Per-line state is not mapped directly. Software first writes a block-select register, and then uses three shared registers that act on the selected block: pending status, live input level and a packed configuration byte. The configuration byte names one line of the selected block, carries its trigger setting and an optional clear, and only takes effect when its strobe bit is set. Reads have no side effects, and read data is combinational from the address.

Top module: `irq_aggregator`

## Requirements
- R1: The registers sit at consecutive byte addresses from the parameter BASE (default 0x1BB): root at +0, master status m (m = 0..3) at +1+m, block select at +5, pending status at +6, configuration at +7, live level at +8. Block select reads back the value last written to it. Any other address reads 0.
- R2: A configuration write takes effect only when bit 7 is set. It then stores bit 0 (1 = level mode), bit 1 (mask falling edge / active-low level) and bit 2 (mask rising edge / active-high level) for line blocksel*8 + bits 6:4. A write with bit 7 clear changes nothing. The configuration register reads 0.
- R3: A configuration write with bits 7 and 3 both set clears the pending bit of the indexed line at that clock edge. The clear wins over an event on that line in the same cycle.
- R4: In edge mode, a line's pending bit is set at the clock edge where the input differs from its level sampled at the previous edge, in a direction whose mask is clear. The sampled level starts at 0 after reset. A line with both masks set never becomes pending.
- R5: In level mode, the pending bit is set at every edge where the input is high with the rising mask clear, or low with the falling mask clear. After a clear it sets again at the next edge if the level is still active.
- R6: After reset, every line has both masks set and edge mode, nothing is pending, block select is 0 and irq_o is low.
- R7: The pending status register returns the eight pending bits of the selected block (bit i = line blocksel*8+i). Reading it does not clear them, and a pending bit only falls through a clear write.
- R8: Bit i of master status m is 1 when block m*8+i has any pending line. Root bit 0 reads 0, and root bit m+1 is 1 when master m has any pending block.
- R9: The live level register returns the current raw inputs of the selected block in the same cycle, bit i = line blocksel*8+i.
- R10: irq_o is high exactly when some root master bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | N_LINES | Interrupt input lines, synchronous to clk |
| bus_addr | input | 10 | Register byte address |
| bus_we | input | 1 | Write enable for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench goes after the ordering between a clear and an event that lands on the same edge. A level-mode line cleared while still active must read 0 right after the clear and pending again one edge later. A design that let the event win would never show the 0, and one that dropped level re-arming would lose the interrupt. A configuration write without its strobe is followed by an edge that only the would-be setting could catch, so a design that ignored the strobe shows a spurious pending bit. Lines in the top block of the last master and in a master's second block check the tree indexing, since an off-by-one there lights the wrong root or master bit. Repeated status reads confirm that reads do not clear anything.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  // register offsets from the base address
  localparam int unsigned OFS_ROOT = 0;
  localparam int unsigned OFS_MST0 = 1;
  localparam int unsigned OFS_BSEL = 5;
  localparam int unsigned OFS_STAT = 6;
  localparam int unsigned OFS_CFG  = 7;
  localparam int unsigned OFS_LIVE = 8;

  // configuration byte fields
  localparam int unsigned CB_LVL    = 0;
  localparam int unsigned CB_MSK_LO = 1;
  localparam int unsigned CB_MSK_HI = 2;
  localparam int unsigned CB_CLR    = 3;
  localparam int unsigned CB_IDX    = 4;
  localparam int unsigned CB_STB    = 7;

  typedef struct packed {
    logic lvl;
    logic msk_lo;
    logic msk_hi;
  } line_cfg_t;

  localparam line_cfg_t CFG_RESET = '{lvl: 1'b0, msk_lo: 1'b1, msk_hi: 1'b1};
endpackage

// File: rtl/irqagg_line.sv
module irqagg_line
  import irqagg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      level_i,
  input  logic      cfg_we_i,
  input  logic      clr_i,
  input  line_cfg_t cfg_i,
  output logic      pend_o,
  output line_cfg_t cfg_o,
  output logic      prev_o
);
  logic      pend_q, pend_d;
  logic      prev_q;
  line_cfg_t cfg_q;
  logic      rise, fall, hit;

  always_comb begin
    rise = level_i & ~prev_q;
    fall = ~level_i & prev_q;
    if (cfg_q.lvl) begin
      hit = (level_i & ~cfg_q.msk_hi) | (~level_i & ~cfg_q.msk_lo);
    end else begin
      hit = (rise & ~cfg_q.msk_hi) | (fall & ~cfg_q.msk_lo);
    end
    pend_d = pend_q | hit;
    if (cfg_we_i && clr_i) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      prev_q <= 1'b0;
      cfg_q  <= CFG_RESET;
    end else begin
      pend_q <= pend_d;
      prev_q <= level_i;
      if (cfg_we_i) begin
        cfg_q <= cfg_i;
      end
    end
  end

  assign pend_o = pend_q;
  assign cfg_o  = cfg_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/irqagg_tree.sv
module irqagg_tree #(
  parameter int unsigned N_BLK = 32,
  localparam int unsigned N_MST = (N_BLK + 7) / 8
) (
  input  logic [N_BLK*8-1:0] pend_i,
  output logic [N_BLK-1:0]   blk_any_o,
  output logic [N_MST-1:0]   mst_any_o
);
  logic [N_MST*8-1:0] blk_pad;

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    assign blk_any_o[b] = |pend_i[b*8 +: 8];
  end

  always_comb begin
    blk_pad = '0;
    blk_pad[N_BLK-1:0] = blk_any_o;
  end

  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    assign mst_any_o[m] = |blk_pad[m*8 +: 8];
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int unsigned N_LINES = 256,
  parameter logic [9:0]  BASE    = 10'h1BB,
  localparam int unsigned LW     = $clog2(N_LINES),
  localparam int unsigned N_BLK  = N_LINES / 8,
  localparam int unsigned BW     = $clog2(N_BLK),
  localparam int unsigned N_MST  = (N_BLK + 7) / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_i,
  input  logic [9:0]         bus_addr,
  input  logic               bus_we,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  output logic               irq_o
);
  localparam logic [9:0] A_ROOT = BASE + 10'(OFS_ROOT);
  localparam logic [9:0] A_MST0 = BASE + 10'(OFS_MST0);
  localparam logic [9:0] A_BSEL = BASE + 10'(OFS_BSEL);
  localparam logic [9:0] A_STAT = BASE + 10'(OFS_STAT);
  localparam logic [9:0] A_CFG  = BASE + 10'(OFS_CFG);
  localparam logic [9:0] A_LIVE = BASE + 10'(OFS_LIVE);

  logic [BW-1:0]      bsel_q, bsel_d;
  logic               bsel_we;
  logic               cfg_we;
  logic [LW-1:0]      cfg_idx;
  line_cfg_t          cfg_wr;
  logic [N_LINES-1:0] pend_vec, mhi_vec, mlo_vec, lvl_vec, prev_vec;
  logic [N_BLK-1:0]   blk_any;
  logic [N_MST-1:0]   mst_any;
  logic [31:0]        blk_pad;
  logic [7:0]         root_byte;
  logic [LW-1:0]      win_base;

  // write decode
  always_comb begin
    bsel_we = bus_we && (bus_addr == A_BSEL);
    bsel_d  = bus_wdata[BW-1:0];
    cfg_we  = bus_we && (bus_addr == A_CFG) && bus_wdata[CB_STB];
    cfg_idx = {bsel_q, bus_wdata[CB_IDX +: 3]};
    cfg_wr  = '{lvl:    bus_wdata[CB_LVL],
                msk_lo: bus_wdata[CB_MSK_LO],
                msk_hi: bus_wdata[CB_MSK_HI]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsel_q <= '0;
    end else if (bsel_we) begin
      bsel_q <= bsel_d;
    end
  end

  // per-line trigger cells
  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    line_cfg_t cfg_l;
    irqagg_line u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_i  (line_i[l]),
      .cfg_we_i (cfg_we && (cfg_idx == LW'(l))),
      .clr_i    (bus_wdata[CB_CLR]),
      .cfg_i    (cfg_wr),
      .pend_o   (pend_vec[l]),
      .cfg_o    (cfg_l),
      .prev_o   (prev_vec[l])
    );
    assign mhi_vec[l] = cfg_l.msk_hi;
    assign mlo_vec[l] = cfg_l.msk_lo;
    assign lvl_vec[l] = cfg_l.lvl;
  end

  irqagg_tree #(.N_BLK(N_BLK)) u_tree (
    .pend_i    (pend_vec),
    .blk_any_o (blk_any),
    .mst_any_o (mst_any)
  );

  // read path
  always_comb begin
    blk_pad = '0;
    blk_pad[N_BLK-1:0] = blk_any;
    root_byte = '0;
    root_byte[N_MST:1] = mst_any;
    win_base = {bsel_q, 3'b000};
    bus_rdata = '0;
    if (bus_addr == A_ROOT) begin
      bus_rdata = root_byte;
    end else if (bus_addr >= A_MST0 && bus_addr < A_MST0 + 10'd4) begin
      bus_rdata = blk_pad[8*int'(bus_addr - A_MST0) +: 8];
    end else if (bus_addr == A_BSEL) begin
      bus_rdata = 8'(bsel_q);
    end else if (bus_addr == A_STAT) begin
      bus_rdata = pend_vec[win_base +: 8];
    end else if (bus_addr == A_LIVE) begin
      bus_rdata = line_i[win_base +: 8];
    end
  end

  assign irq_o = |root_byte;
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
  parameter int unsigned N_LINES = 256,
  parameter logic [9:0]  BASE    = 10'h1BB,
  localparam int unsigned LW     = $clog2(N_LINES),
  localparam int unsigned BW     = $clog2(N_LINES / 8)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [9:0]         bus_addr,
  input logic [7:0]         bus_wdata,
  input logic [BW-1:0]      bsel,
  input logic [N_LINES-1:0] line_i,
  input logic [N_LINES-1:0] pend,
  input logic [N_LINES-1:0] mhi,
  input logic [N_LINES-1:0] mlo,
  input logic [N_LINES-1:0] lvl,
  input logic [N_LINES-1:0] prev,
  input logic               irq_o
);
  logic          cfg_hit, clr_wr, nostb_wr;
  logic [LW-1:0] idx;

  assign cfg_hit  = bus_we && (bus_addr == BASE + 10'd7);
  assign clr_wr   = cfg_hit && bus_wdata[7] && bus_wdata[3];
  assign nostb_wr = cfg_hit && !bus_wdata[7];
  assign idx      = {bsel, bus_wdata[6:4]};

  // R3: a strobed clear leaves the indexed line not pending
  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (pend[$past(idx)] == 1'b0));

  // R2: a write without strobe leaves all configuration unchanged
  a_r2_no_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    nostb_wr |=> ($stable(mhi) && $stable(mlo) && $stable(lvl)));

  // R4: a line masked in both directions never becomes pending
  a_r4_masked_never_pends: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & $past(mhi) & $past(mlo)) == '0));

  // R4: an edge-mode line only becomes pending after its input changed
  a_r4_edge_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(lvl) & ~($past(line_i) ^ $past(prev))) == '0));

  // R7: pending bits only fall through a clear write
  a_r7_fall_only_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pend & $past(pend)) != '0) |-> $past(clr_wr));

  // R10: output follows the presence of any pending line
  a_r10_irq_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (pend != '0));
endmodule

bind irq_aggregator irqagg_checker #(.N_LINES(N_LINES), .BASE(BASE)) u_irqagg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bsel      (bsel_q),
  .line_i    (line_i),
  .pend      (pend_vec),
  .mhi       (mhi_vec),
  .mlo       (mlo_vec),
  .lvl       (lvl_vec),
  .prev      (prev_vec),
  .irq_o     (irq_o)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  localparam int NL = 256;
  localparam logic [9:0] B = 10'h1BB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic [9:0]    bus_addr = 10'h000;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_wdata = 8'h00;
  logic [7:0]    bus_rdata;
  logic          irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .line_i(lines), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  bit [NL-1:0] m_pend, m_mhi, m_mlo, m_lvl, m_prev;
  int m_bsel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_mhi = '1; m_mlo = '1; m_lvl = '0; m_prev = '0; m_bsel = 0;
    end else begin
      bit [NL-1:0] np;
      np = m_pend;
      for (int i = 0; i < NL; i++) begin
        bit h, lo_ok, hi_ok;
        hi_ok = !m_mhi[i];
        lo_ok = !m_mlo[i];
        if (m_lvl[i]) h = (lines[i] && hi_ok) || (!lines[i] && lo_ok);
        else h = (lines[i] && !m_prev[i] && hi_ok) || (!lines[i] && m_prev[i] && lo_ok);
        if (h) np[i] = 1'b1;
      end
      if (bus_we && bus_addr == B + 10'd7 && bus_wdata[7]) begin
        int k;
        k = m_bsel * 8 + int'(bus_wdata[6:4]);
        m_lvl[k] = bus_wdata[0];
        m_mlo[k] = bus_wdata[1];
        m_mhi[k] = bus_wdata[2];
        if (bus_wdata[3]) np[k] = 1'b0;
      end
      if (bus_we && bus_addr == B + 10'd5) m_bsel = int'(bus_wdata[4:0]);
      m_prev = lines;
      m_pend = np;
    end
  end

  function automatic logic [7:0] exp_read(input logic [9:0] a);
    logic [7:0] r;
    r = 8'h00;
    if (a == B) begin
      for (int m = 0; m < 4; m++) if (m_pend[m*64 +: 64] != '0) r[m+1] = 1'b1;
    end else if (a >= B + 10'd1 && a <= B + 10'd4) begin
      int m;
      m = int'(a - B) - 1;
      for (int i = 0; i < 8; i++) if (m_pend[(m*8+i)*8 +: 8] != '0) r[i] = 1'b1;
    end else if (a == B + 10'd5) r = 8'(m_bsel);
    else if (a == B + 10'd6) r = m_pend[m_bsel*8 +: 8];
    else if (a == B + 10'd8) r = lines[m_bsel*8 +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !done) begin
      chk(irq_o == (m_pend != '0), "R10 cycle irq", {7'd0, irq_o}, {7'd0, (m_pend != '0)});
      chk(bus_rdata == exp_read(bus_addr), "R1 cycle read", bus_rdata, exp_read(bus_addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    #3;
    chk(bus_rdata == e, tag, bus_rdata, e);
  endtask

  task automatic set_line(input int k, input logic v);
    @(negedge clk);
    lines[k] = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6 reset state
    rd(B, 8'h00, "R6 root after reset");
    rd(B + 10'd5, 8'h00, "R6 block select after reset");
    chk(irq_o == 1'b0, "R6 irq after reset", {7'd0, irq_o}, 8'h00);
    // R4 all masked: toggling does nothing
    @(negedge clk); lines = '1;
    @(negedge clk); lines = '0;
    rd(B + 10'd6, 8'h00, "R4 masked lines stay idle");
    rd(B, 8'h00, "R6 root idle with masked lines");

    // R4 rising edge on line 5 (block 0)
    wr(B + 10'd5, 8'h00);
    wr(B + 10'd7, 8'hD2);
    set_line(5, 1'b1);
    rd(B + 10'd6, 8'h20, "R4 rising edge pends");
    rd(B + 10'd1, 8'h01, "R8 master0 block0");
    rd(B, 8'h02, "R8 root master0");
    chk(irq_o == 1'b1, "R10 irq high", {7'd0, irq_o}, 8'h01);
    rd(B + 10'd6, 8'h20, "R7 status read does not clear");
    set_line(5, 1'b0);
    wr(B + 10'd7, 8'hDA);
    rd(B + 10'd6, 8'h00, "R3 clear line 5");
    chk(irq_o == 1'b0, "R10 irq low after clear", {7'd0, irq_o}, 8'h00);

    // R4 falling edge on line 74 (block 9, master 1 bit 1)
    set_line(74, 1'b1);
    wr(B + 10'd5, 8'h09);
    wr(B + 10'd7, 8'hA4);
    set_line(74, 1'b0);
    rd(B + 10'd6, 8'h04, "R4 falling edge pends");
    rd(B + 10'd2, 8'h02, "R8 master1 block9");
    rd(B, 8'h04, "R8 root master1");
    wr(B + 10'd7, 8'hAC);
    rd(B, 8'h00, "R3 root clears");

    // R2 write without strobe is ignored
    wr(B + 10'd7, 8'h22);
    set_line(74, 1'b1);
    rd(B + 10'd6, 8'h00, "R2 unstrobed config ignored (rise)");
    set_line(74, 1'b0);
    rd(B + 10'd6, 8'h04, "R2 old config still active (fall)");
    wr(B + 10'd7, 8'hAC);

    // R5 active-high level on line 255 (block 31, master 3 bit 7)
    wr(B + 10'd5, 8'h1F);
    wr(B + 10'd7, 8'hF3);
    set_line(255, 1'b1);
    rd(B + 10'd6, 8'h80, "R5 level high pends");
    rd(B + 10'd4, 8'h80, "R8 master3 block31");
    rd(B, 8'h10, "R8 root master3");
    wr(B + 10'd7, 8'hFB);
    bus_addr = B + 10'd6;
    #3;
    chk(bus_rdata == 8'h00, "R3 clear wins over level event", bus_rdata, 8'h00);
    rd(B + 10'd6, 8'h80, "R5 level re-pends after clear");
    set_line(255, 1'b0);
    wr(B + 10'd7, 8'hFB);
    rd(B + 10'd6, 8'h00, "R5 inactive level stays clear");

    // R5 active-low level on line 8 (block 1)
    wr(B + 10'd5, 8'h01);
    wr(B + 10'd7, 8'h85);
    rd(B + 10'd6, 8'h01, "R5 level low pends");
    set_line(8, 1'b1);
    wr(B + 10'd7, 8'h8D);
    rd(B + 10'd6, 8'h00, "R5 low level cleared while high");

    // R4 both edges on line 9
    wr(B + 10'd7, 8'h90);
    set_line(9, 1'b1);
    rd(B + 10'd6, 8'h02, "R4 both-edge rise");
    wr(B + 10'd7, 8'h98);
    set_line(9, 1'b0);
    rd(B + 10'd6, 8'h02, "R4 both-edge fall");
    wr(B + 10'd7, 8'h98);

    // R9 live level, R1/R2 misc reads
    set_line(15, 1'b1);
    rd(B + 10'd8, 8'h81, "R9 live level of block 1");
    rd(B + 10'd7, 8'h00, "R2 config reads zero");
    rd(B - 10'd1, 8'h00, "R1 unmapped address reads zero");
    rd(B + 10'd5, 8'h01, "R1 block select readback");

    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule